// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight interrupt request inputs and turns them into a single interrupt output toward a processor. It also supplies an 8-bit vector when the processor acknowledges. Software reaches it through a byte-wide bus with two addresses: a command address and a data address.

After reset, an initialization word written to the command address starts a short sequence of data-address writes. That sequence sets, in order:
- the vector base;
- the cascade wiring word, unless single mode was chosen;
- the mode word, if one was announced.

Once the sequence is complete, data-address writes load the interrupt mask. Reads of the data address return the mask.

Requests latch on rising edges or follow the input level, depending on the trigger mode chosen at initialization. They are resolved at fixed priority, with line 0 highest. A request is forwarded only if it outranks everything currently in service. An acknowledge moves the winning request into service and drives the vector, which is the base plus the line number. Service is closed either by an end-of-interrupt command or automatically. An acknowledge with no valid request returns the vector of the lowest-priority line, marking the request as spurious. The cascade word is exported so that two instances can be wired as a master and a slave.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask is all ones, int_req is low, cfg_ready is low and cfg_cascade is 0x00.
- R2: A command write with bit 4 set starts initialization. Its bit 0 announces a mode word and its bit 1 selects single mode. The next data writes set the base, then the cascade word (skipped in single mode), then the mode word (skipped when bit 0 was clear). cfg_ready rises only after the last required word.
- R3: While int_ack is high, int_vector equals the base plus the index of the line being granted (modulo 256).
- R4: After initialization, a data write loads the mask from bus_wdata and a data read (bus_addr=1, bus_rd=1) returns it. A mask bit of 1 blocks its line. bus_rdata is 0x00 when bus_rd is low. Initialization sets the mask to all ones.
- R5: Priority is fixed with line 0 highest. int_req is high only when an unmasked pending line has a lower index than every line in service.
- R6: Initialization bit 3 clear selects edge mode. A rising input edge latches a request, which is visible to int_req one clock edge later. After being serviced, a line must go low before it can latch again.
- R7: Initialization bit 3 set selects level mode, in which the pending request follows the input level within the same cycle.
- R8: An acknowledge with int_req high puts the granted line in service, which blocks that line and every lower-priority line.
- R9: A command write of 0x20 clears the highest-priority in-service line.
- R10: Mode word bit 1 set enables automatic end of service: an acknowledge leaves nothing in service.
- R11: An acknowledge while int_req is low (for example, a line-7 request that went away) returns base + 7 and leaves nothing newly in service.
- R12: cfg_cascade holds the cascade word from initialization, and holds 0x00 when single mode skipped it.
- R13: Data writes before initialization completes do not change the mask. Command writes that neither start initialization nor equal 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (mask), combinational |
| irq_in | input | NLINES | Interrupt request inputs |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge from the processor, one cycle |
| int_vector | output | 8 | Vector, valid while int_ack is high |
| cfg_ready | output | 1 | Initialization complete |
| cfg_cascade | output | 8 | Cascade wiring word |

## Verification
Bus writes take effect at the rising edge on which the strobe is sampled. In edge mode a new request reaches int_req one edge after the input rises. In level mode, and after a mask change, int_req follows combinationally. The vector is combinational during the acknowledge cycle, and the in-service change is visible right after the edge that ends that cycle. Each bench task drives its inputs just after a falling edge and samples one time unit after the falling edge that follows the required number of rising edges. Combinational results are therefore read in the same half cycle, and registered results one full cycle later.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [2:0] {
      ST_UNINIT,
      ST_BASE,
      ST_CASC,
      ST_MODE,
      ST_READY
   } init_st_t;

   localparam logic       ADDR_CMD  = 1'b0;
   localparam logic       ADDR_DATA = 1'b1;
   localparam logic [7:0] CMD_EOI   = 8'h20;
   localparam int         BIT_START = 4;
   localparam int         BIT_MODEW = 0;
   localparam int         BIT_SINGL = 1;
   localparam int         BIT_LEVEL = 3;
   localparam int         BIT_AUTO  = 1;

endpackage

// File: rtl/pic_cfg_ctrl.sv
module pic_cfg_ctrl
   import pic_pkg::*;
#(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic              addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [NLINES-1:0] mask,
   output logic [7:0]        base,
   output logic [7:0]        cascade,
   output logic              level_mode,
   output logic              auto_eoi,
   output logic              ready,
   output logic              init_pulse,
   output logic              eoi_pulse
);

   init_st_t state_q;
   logic     need_mode_q;
   logic     single_q;
   logic     cmd_wr;
   logic     dat_wr;

   assign cmd_wr     = wr && (addr == ADDR_CMD);
   assign dat_wr     = wr && (addr == ADDR_DATA);
   assign ready      = (state_q == ST_READY);
   assign init_pulse = cmd_wr && wdata[BIT_START];
   assign eoi_pulse  = cmd_wr && (wdata == CMD_EOI) && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_UNINIT;
         mask        <= '1;
         base        <= '0;
         cascade     <= '0;
         need_mode_q <= 1'b0;
         single_q    <= 1'b0;
         level_mode  <= 1'b0;
         auto_eoi    <= 1'b0;
      end else if (init_pulse) begin
         state_q     <= ST_BASE;
         mask        <= '1;
         cascade     <= '0;
         auto_eoi    <= 1'b0;
         need_mode_q <= wdata[BIT_MODEW];
         single_q    <= wdata[BIT_SINGL];
         level_mode  <= wdata[BIT_LEVEL];
      end else if (dat_wr) begin
         case (state_q)
            ST_BASE: begin
               base <= wdata;
               if (!single_q)
                  state_q <= ST_CASC;
               else if (need_mode_q)
                  state_q <= ST_MODE;
               else
                  state_q <= ST_READY;
            end
            ST_CASC: begin
               cascade <= wdata;
               state_q <= need_mode_q ? ST_MODE : ST_READY;
            end
            ST_MODE: begin
               auto_eoi <= wdata[BIT_AUTO];
               state_q  <= ST_READY;
            end
            ST_READY: mask <= wdata[NLINES-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (rd && addr == ADDR_DATA)
         rdata[NLINES-1:0] = mask;
   end

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_pulse,
   input  logic              level_mode,
   input  logic [NLINES-1:0] lines_in,
   input  logic [NLINES-1:0] ack_clr,
   output logic [NLINES-1:0] irr
);

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic prev_q;
      logic armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
         end else begin
            prev_q <= lines_in[g];
            if (init_pulse || ack_clr[g] || !lines_in[g])
               armed_q <= 1'b0;
            else if (!prev_q)
               armed_q <= 1'b1;
         end
      end

      assign irr[g] = level_mode ? lines_in[g] : (armed_q & lines_in[g]);
   end

endmodule

// File: rtl/pic_prio_core.sv
module pic_prio_core #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irr,
   input  logic [NLINES-1:0] mask,
   input  logic [7:0]        base,
   input  logic              auto_eoi,
   input  logic              ready,
   input  logic              init_pulse,
   input  logic              eoi_pulse,
   input  logic              ack,
   output logic              int_req,
   output logic [7:0]        vec_out,
   output logic [NLINES-1:0] ack_clr,
   output logic [NLINES-1:0] isr
);

   localparam int             IW   = (NLINES > 1) ? $clog2(NLINES) : 1;
   localparam logic [IW-1:0]  SPUR = IW'(NLINES - 1);

   function automatic logic [IW-1:0] first_set(input logic [NLINES-1:0] v);
      logic [IW-1:0] r;
      r = '0;
      for (int i = NLINES - 1; i >= 0; i--)
         if (v[i]) r = IW'(i);
      return r;
   endfunction

   logic [NLINES-1:0] pend;
   logic [NLINES-1:0] isr_n;
   logic [IW-1:0]     pend_top;
   logic [IW-1:0]     isr_top;
   logic [IW-1:0]     sel;
   logic [7:0]        sel8;
   logic              grant;

   assign pend     = irr & ~mask & {NLINES{ready}};
   assign pend_top = first_set(pend);
   assign isr_top  = first_set(isr);
   assign int_req  = (|pend) && (!(|isr) || (pend_top < isr_top));
   assign grant    = ack && int_req;
   assign sel      = int_req ? pend_top : SPUR;

   always_comb begin
      sel8          = '0;
      sel8[IW-1:0]  = sel;
      vec_out       = ack ? (base + sel8) : 8'h00;
      ack_clr       = '0;
      if (grant) ack_clr[pend_top] = 1'b1;
   end

   always_comb begin
      isr_n = isr;
      if (eoi_pulse && (|isr)) isr_n[isr_top] = 1'b0;
      if (grant && !auto_eoi)  isr_n[pend_top] = 1'b1;
      if (init_pulse)          isr_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr <= '0;
      else        isr <= isr_n;
   end

endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NLINES-1:0] irq_in,
   output logic              int_req,
   input  logic              int_ack,
   output logic [7:0]        int_vector,
   output logic              cfg_ready,
   output logic [7:0]        cfg_cascade
);

   if (NLINES < 2 || NLINES > 8) begin : g_bad_lines
      $error("prio_intc: NLINES must lie in 2..8");
   end

   logic [NLINES-1:0] cur_mask;
   logic [NLINES-1:0] req_vec;
   logic [NLINES-1:0] isr_vec;
   logic [NLINES-1:0] clr_vec;
   logic [7:0]        cfg_base;
   logic              level_mode;
   logic              auto_eoi;
   logic              init_pulse;
   logic              eoi_pulse;

   pic_cfg_ctrl #(.NLINES(NLINES)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .rdata      (bus_rdata),
      .mask       (cur_mask),
      .base       (cfg_base),
      .cascade    (cfg_cascade),
      .level_mode (level_mode),
      .auto_eoi   (auto_eoi),
      .ready      (cfg_ready),
      .init_pulse (init_pulse),
      .eoi_pulse  (eoi_pulse)
   );

   pic_req_latch #(.NLINES(NLINES)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_pulse (init_pulse),
      .level_mode (level_mode),
      .lines_in   (irq_in),
      .ack_clr    (clr_vec),
      .irr        (req_vec)
   );

   pic_prio_core #(.NLINES(NLINES)) u_prio (
      .clk        (clk),
      .rst_n      (rst_n),
      .irr        (req_vec),
      .mask       (cur_mask),
      .base       (cfg_base),
      .auto_eoi   (auto_eoi),
      .ready      (cfg_ready),
      .init_pulse (init_pulse),
      .eoi_pulse  (eoi_pulse),
      .ack        (int_ack),
      .int_req    (int_req),
      .vec_out    (int_vector),
      .ack_clr    (clr_vec),
      .isr        (isr_vec)
   );

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int NLINES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              int_req,
   input logic              int_ack,
   input logic [7:0]        int_vector,
   input logic              ready,
   input logic [7:0]        base,
   input logic [NLINES-1:0] mask,
   input logic [NLINES-1:0] irr,
   input logic [NLINES-1:0] isr,
   input logic              auto_eoi,
   input logic              eoi_pulse
);

   logic       cmd_wr;
   logic [7:0] vec_off;

   assign cmd_wr  = bus_wr && !bus_addr;
   assign vec_off = int_vector - base;

   p_vec_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && int_ack) |-> (vec_off < 8'(NLINES)));

   p_mask_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (mask == '1));

   p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == 8'h00));

   p_req_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> ((irr & ~mask) != '0));

   p_ack_adds_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && int_ack && int_req && !auto_eoi && !cmd_wr)
      |=> ($countones(isr) == $countones($past(isr)) + 1));

   p_eoi_drops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_pulse && (isr != '0) && !int_ack)
      |=> ($countones(isr) == $countones($past(isr)) - 1));

   p_auto_keeps_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && auto_eoi && !cmd_wr) |=> (isr == $past(isr)));

   p_spurious_keeps_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_req && !cmd_wr) |=> (isr == $past(isr)));

endmodule

bind prio_intc prio_intc_chk #(.NLINES(NLINES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .int_req    (int_req),
   .int_ack    (int_ack),
   .int_vector (int_vector),
   .ready      (cfg_ready),
   .base       (cfg_base),
   .mask       (cur_mask),
   .irr        (req_vec),
   .isr        (isr_vec),
   .auto_eoi   (auto_eoi),
   .eoi_pulse  (eoi_pulse)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] irq_in = 8'h00;
   logic       int_req;
   logic       int_ack = 1'b0;
   logic [7:0] int_vector;
   logic       cfg_ready;
   logic [7:0] cfg_cascade;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_intc #(.NLINES(8)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .int_req(int_req), .int_ack(int_ack),
      .int_vector(int_vector), .cfg_ready(cfg_ready), .cfg_cascade(cfg_cascade)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wr_bus(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; #1;
   endtask

   task automatic rd_mask(output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 1'b1; #1;
      d = bus_rdata;
      bus_rd = 1'b0; #1;
   endtask

   task automatic set_line(input int i, input logic v);
      @(negedge clk);
      irq_in[i] = v; #1;
   endtask

   task automatic do_ack(output logic [7:0] v);
      @(negedge clk);
      int_ack = 1'b1; #1;
      v = int_vector;
      @(negedge clk);
      int_ack = 1'b0; #1;
   endtask

   task automatic t_reset();
      logic [7:0] m;
      check("R1 int_req after reset", {7'd0, int_req}, 8'h00);
      check("R1 ready after reset", {7'd0, cfg_ready}, 8'h00);
      check("R1 cascade after reset", cfg_cascade, 8'h00);
      rd_mask(m);
      check("R1 mask after reset", m, 8'hFF);
   endtask

   task automatic t_pre_init();
      logic [7:0] m;
      wr_bus(1'b1, 8'h00);
      rd_mask(m);
      check("R13 data write before init ignored", m, 8'hFF);
      check("R13 still not ready", {7'd0, cfg_ready}, 8'h00);
   endtask

   task automatic t_init_cascade();
      wr_bus(1'b0, 8'h11);
      wr_bus(1'b1, 8'h20);
      wr_bus(1'b1, 8'h04);
      check("R2 not ready before mode word", {7'd0, cfg_ready}, 8'h00);
      wr_bus(1'b1, 8'h01);
      check("R2 ready after mode word", {7'd0, cfg_ready}, 8'h01);
      check("R12 cascade word", cfg_cascade, 8'h04);
   endtask

   task automatic t_mask();
      logic [7:0] m;
      wr_bus(1'b1, 8'hA5);
      rd_mask(m);
      check("R4 mask readback", m, 8'hA5);
      check("R4 rdata idle", bus_rdata, 8'h00);
      wr_bus(1'b0, 8'h05);
      rd_mask(m);
      check("R13 stray command ignored mask", m, 8'hA5);
      check("R13 stray command ignored ready", {7'd0, cfg_ready}, 8'h01);
      wr_bus(1'b1, 8'h08);
   endtask

   task automatic t_edge_service();
      logic [7:0] v;
      set_line(3, 1'b1); step();
      check("R4 masked line blocked", {7'd0, int_req}, 8'h00);
      wr_bus(1'b1, 8'h00);
      check("R6 latched edge after unmask", {7'd0, int_req}, 8'h01);
      do_ack(v);
      check("R3 vector line 3", v, 8'h23);
      check("R8 in service drops int_req", {7'd0, int_req}, 8'h00);
      set_line(5, 1'b1); step();
      check("R5 lower line blocked by service", {7'd0, int_req}, 8'h00);
      set_line(1, 1'b1); step();
      check("R5 higher line preempts", {7'd0, int_req}, 8'h01);
      do_ack(v);
      check("R3 vector line 1", v, 8'h21);
      wr_bus(1'b0, 8'h20);
      check("R9 eoi clears line 1 only", {7'd0, int_req}, 8'h00);
      wr_bus(1'b0, 8'h20);
      check("R9 eoi clears line 3", {7'd0, int_req}, 8'h01);
      do_ack(v);
      check("R3 vector line 5", v, 8'h25);
      wr_bus(1'b0, 8'h20);
      check("R6 held lines do not relatch", {7'd0, int_req}, 8'h00);
      set_line(3, 1'b0);
      set_line(3, 1'b1); step();
      check("R6 new edge relatches", {7'd0, int_req}, 8'h01);
      do_ack(v);
      check("R3 vector line 3 again", v, 8'h23);
      wr_bus(1'b0, 8'h20);
      @(negedge clk); irq_in = 8'h00; #1;
   endtask

   task automatic t_priority();
      logic [7:0] v;
      @(negedge clk); irq_in[6] = 1'b1; irq_in[4] = 1'b1;
      step();
      do_ack(v);
      check("R5 line 4 wins over 6", v, 8'h24);
      wr_bus(1'b0, 8'h20);
      do_ack(v);
      check("R5 line 6 next", v, 8'h26);
      wr_bus(1'b0, 8'h20);
      @(negedge clk); irq_in = 8'h00; #1;
   endtask

   task automatic t_spurious();
      logic [7:0] v;
      set_line(7, 1'b1); step();
      check("R11 line 7 requests", {7'd0, int_req}, 8'h01);
      set_line(7, 1'b0);
      check("R11 vanished request", {7'd0, int_req}, 8'h00);
      do_ack(v);
      check("R11 spurious vector", v, 8'h27);
      set_line(7, 1'b1); step();
      check("R11 no in-service after spurious", {7'd0, int_req}, 8'h01);
      do_ack(v);
      check("R3 vector line 7", v, 8'h27);
      wr_bus(1'b0, 8'h20);
      set_line(7, 1'b0);
   endtask

   task automatic t_level();
      logic [7:0] v;
      wr_bus(1'b0, 8'h1A);
      wr_bus(1'b1, 8'h40);
      check("R2 single no mode word ready", {7'd0, cfg_ready}, 8'h01);
      check("R12 cascade skipped", cfg_cascade, 8'h00);
      wr_bus(1'b1, 8'h00);
      set_line(2, 1'b1);
      check("R7 level request immediate", {7'd0, int_req}, 8'h01);
      set_line(2, 1'b0);
      check("R7 level request follows low", {7'd0, int_req}, 8'h00);
      set_line(2, 1'b1);
      do_ack(v);
      check("R3 level vector line 2", v, 8'h42);
      check("R8 level line in service", {7'd0, int_req}, 8'h00);
      wr_bus(1'b0, 8'h20);
      check("R7 level re-requests after eoi", {7'd0, int_req}, 8'h01);
      do_ack(v);
      set_line(2, 1'b0);
      wr_bus(1'b0, 8'h20);
      set_line(7, 1'b1);
      set_line(7, 1'b0);
      do_ack(v);
      check("R11 level spurious vector", v, 8'h47);
   endtask

   task automatic t_auto();
      logic [7:0] v;
      wr_bus(1'b0, 8'h13);
      wr_bus(1'b1, 8'h60);
      check("R2 single awaiting mode word", {7'd0, cfg_ready}, 8'h00);
      wr_bus(1'b1, 8'h03);
      check("R2 ready after mode word", {7'd0, cfg_ready}, 8'h01);
      wr_bus(1'b1, 8'h00);
      set_line(5, 1'b1); step();
      do_ack(v);
      check("R3 auto vector line 5", v, 8'h65);
      set_line(6, 1'b1); step();
      check("R10 nothing left in service", {7'd0, int_req}, 8'h01);
      do_ack(v);
      check("R10 auto vector line 6", v, 8'h66);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;
      t_reset();
      t_pre_init();
      t_init_cascade();
      t_mask();
      t_edge_service();
      t_priority();
      t_spurious();
      t_level();
      t_auto();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule